// File: doc/BRIEF.md
# Periodic Clock Pulse Correction Unit

This block divides a 32768 Hz input pulse stream into a one-second tick for a time-of-day core, and trims the accuracy of that tick. The seconds are grouped into correction windows of either 20 or 60 seconds. In the last second of every window the divider is made shorter or longer by an even number of input pulses. The effect is the same as adding pulses to the stream or removing them from it. Over a 20 s window one step of two pulses is worth about 3051 ppb. Over a 60 s window it is worth about 1017 ppb.

Software writes one 8-bit correction word. The word waits in a pending register, and a busy flag stays high for as long as it waits. At the next window boundary the word becomes active and the flag drops. A write made while the flag is high is discarded. The active word can be read back on an output port.

Top module: `tick_trim`

## Requirements
- R1: The correction word has three fields. Bit 7 selects the window length: 1 gives the long window (LONG_SECONDS, 60 by default) and 0 gives the short window (SHORT_SECONDS, 20 by default). Bit 6 selects the direction: 1 removes pulses and 0 adds them. Bits 5:0 hold the amount code. Once loaded, the word appears unchanged on `active_cfg`.
- R2: An amount code of zero means no correction, whatever the direction bit says. Every second is then exactly DIV_COUNT input pulses long.
- R3: In add mode an amount code v gives v−1 steps, so v=1 gives none. Each step shortens the final second of the window by two input pulses.
- R4: In remove mode an amount code v gives ((~v) & 6'h3F) + 1 steps. Each step lengthens the final second of the window by two input pulses.
- R5: Only the final second of a window is altered. Every other second is exactly DIV_COUNT pulses long, and a second never departs from DIV_COUNT by more than 126 pulses.
- R6: A window spans SHORT_SECONDS or LONG_SECONDS ticks, as bit 7 of the active word selects.
- R7: A write while `busy` is low is accepted, and `busy` is high in the following cycle.
- R8: `busy` stays high until the tick that ends the current window. On that tick the pending word becomes active and `busy` falls in the same cycle as the tick.
- R9: A write while `busy` is high has no effect. Neither the pending word nor the active word changes.
- R10: After reset, `busy` is 0 and `active_cfg` is 0. The first tick follows DIV_COUNT input pulses.
- R11: `sec_tick` is high for exactly one clock cycle, in the cycle after the input pulse that completes the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_en | input | 1 | One-cycle strobe for each timebase input pulse |
| wr_en | input | 1 | Write strobe for the correction word |
| wr_data | input | 8 | Correction word: window select, direction, amount code |
| busy | output | 1 | High while a written word waits for the window boundary |
| active_cfg | output | 8 | Correction word currently in force |
| sec_tick | output | 1 | One-cycle strobe at the end of each second |

## Verification
The bench goes after the amount-code extremes. In add mode these are code 1 (no steps) and code 63 (62 steps). In remove mode they are code 63 (one step) and code 1 (63 steps). It also covers a zero code with the direction bit set. A design that treated the remove amount as plain binary would stretch the second by the wrong count. A design that applied the step count with the wrong sign would move the tick the wrong way. Both show up as a measured second of the wrong length.

The bench also issues writes while `busy` is high, switches between the two window lengths, and measures the length of every second. A design that took a late write, loaded the word in mid-window, or altered a second other than the last one would give a length or a read-back that the bench's model does not predict.

// File: rtl/tick_trim_pkg.sv
package tick_trim_pkg;

    localparam int CFG_W  = 8;
    localparam int AMT_W  = 6;
    localparam int STEP_W = AMT_W + 1;

    typedef struct packed {
        logic             long_win;
        logic             remove;
        logic [AMT_W-1:0] amount;
    } trim_cfg_t;

    // Number of two-pulse steps encoded by a correction word.
    function automatic logic [STEP_W-1:0] trim_steps(input trim_cfg_t c);
        logic [STEP_W-1:0] s;
        if (c.amount == '0) begin
            s = '0;
        end else if (c.remove) begin
            s = {1'b0, ~c.amount} + STEP_W'(1);
        end else begin
            s = {1'b0, c.amount} - STEP_W'(1);
        end
        return s;
    endfunction

endpackage

// File: rtl/tick_trim_cfg.sv
module tick_trim_cfg
    import tick_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  trim_cfg_t wr_cfg,
    input  logic      boundary,
    output trim_cfg_t active,
    output logic      busy
);

    trim_cfg_t pend_q;
    trim_cfg_t active_q;
    logic      busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            active_q <= '0;
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            if (boundary) begin
                active_q <= pend_q;
                busy_q   <= 1'b0;
            end
        end else if (wr_en) begin
            pend_q <= wr_cfg;
            busy_q <= 1'b1;
        end
    end

    assign active = active_q;
    assign busy   = busy_q;

endmodule

// File: rtl/tick_trim_period.sv
module tick_trim_period #(
    parameter int SHORT_SECONDS = 20,
    parameter int LONG_SECONDS  = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic sec_done,
    input  logic long_win,
    output logic last_sec,
    output logic boundary
);

    localparam int SW = (LONG_SECONDS > 1) ? $clog2(LONG_SECONDS) : 1;
    localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_SECONDS - 1);
    localparam logic [SW-1:0] LONG_LAST  = SW'(LONG_SECONDS - 1);

    logic [SW-1:0] sec_q;

    always_comb begin
        last_sec = (sec_q == (long_win ? LONG_LAST : SHORT_LAST));
        boundary = sec_done && last_sec;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
        end else if (sec_done) begin
            sec_q <= last_sec ? '0 : sec_q + SW'(1);
        end
    end

endmodule

// File: rtl/tick_trim_div.sv
module tick_trim_div #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse_en,
    input  logic [CW-1:0] target_len,
    output logic          sec_done,
    output logic          sec_tick
);

    logic [CW-1:0] pcnt_q;
    logic          tick_q;

    assign sec_done = pulse_en && (pcnt_q == target_len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= sec_done;
            if (sec_done) begin
                pcnt_q <= '0;
            end else if (pulse_en) begin
                pcnt_q <= pcnt_q + CW'(1);
            end
        end
    end

    assign sec_tick = tick_q;

endmodule

// File: rtl/tick_trim.sv
module tick_trim
    import tick_trim_pkg::*;
#(
    parameter int DIV_COUNT     = 32768,
    parameter int SHORT_SECONDS = 20,
    parameter int LONG_SECONDS  = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pulse_en,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic             busy,
    output logic [CFG_W-1:0] active_cfg,
    output logic             sec_tick
);

    localparam int MAX_DELTA = 2 * ((1 << AMT_W) - 1);
    localparam int CW        = $clog2(DIV_COUNT + MAX_DELTA + 1);
    localparam logic [CW-1:0] BASE_LEN = CW'(DIV_COUNT);

    trim_cfg_t         active;
    logic              last_sec;
    logic              boundary;
    logic              sec_done;
    logic [STEP_W-1:0] steps;
    logic [CW-1:0]     delta;
    logic [CW-1:0]     target_len;

    tick_trim_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_cfg   (trim_cfg_t'(wr_data)),
        .boundary (boundary),
        .active   (active),
        .busy     (busy)
    );

    tick_trim_period #(
        .SHORT_SECONDS (SHORT_SECONDS),
        .LONG_SECONDS  (LONG_SECONDS)
    ) u_period (
        .clk      (clk),
        .rst      (rst),
        .sec_done (sec_done),
        .long_win (active.long_win),
        .last_sec (last_sec),
        .boundary (boundary)
    );

    always_comb begin
        steps = trim_steps(active);
        delta = CW'({steps, 1'b0});
        if (!last_sec) begin
            target_len = BASE_LEN;
        end else if (active.remove) begin
            target_len = BASE_LEN + delta;
        end else begin
            target_len = BASE_LEN - delta;
        end
    end

    tick_trim_div #(
        .CW (CW)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .pulse_en   (pulse_en),
        .target_len (target_len),
        .sec_done   (sec_done),
        .sec_tick   (sec_tick)
    );

    assign active_cfg = active;

endmodule

// File: rtl/tick_trim_chk.sv
module tick_trim_chk #(
    parameter int DIV_COUNT = 32768
) (
    input logic       clk,
    input logic       rst,
    input logic       pulse_en,
    input logic       wr_en,
    input logic       busy,
    input logic [7:0] active_cfg,
    input logic       sec_tick
);

    int unsigned pulses_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulses_q <= 0;
        end else if (sec_tick) begin
            pulses_q <= pulse_en ? 1 : 0;
        end else if (pulse_en) begin
            pulses_q <= pulses_q + 1;
        end
    end

    assert_len_range_R5: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (pulses_q + 126 >= DIV_COUNT && pulses_q <= DIV_COUNT + 126));

    assert_busy_set_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy);

    assert_busy_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en));

    assert_busy_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> sec_tick);

    assert_active_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_cfg) |-> sec_tick);

    assert_tick_width_R11: assert property (@(posedge clk) disable iff (rst)
        sec_tick |=> !sec_tick);

endmodule

bind tick_trim tick_trim_chk #(.DIV_COUNT(DIV_COUNT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pulse_en   (pulse_en),
    .wr_en      (wr_en),
    .busy       (busy),
    .active_cfg (active_cfg),
    .sec_tick   (sec_tick)
);

// File: tb/tick_trim_tb.sv
module tick_trim_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV       = 200;
    localparam int SHORT_S   = 3;
    localparam int LONG_S    = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pulse_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       busy;
    logic [7:0] active_cfg;
    logic       sec_tick;

    int checks = 0;
    int errors = 0;
    bit run_mon = 1'b0;
    bit finished = 1'b0;

    // bench model
    logic [7:0] m_active = 8'h00;
    logic [7:0] m_pend = 8'h00;
    bit         m_pvalid = 1'b0;
    int         m_idx = 0;
    int         m_ticks = 0;

    tick_trim #(
        .DIV_COUNT     (DIV),
        .SHORT_SECONDS (SHORT_S),
        .LONG_SECONDS  (LONG_S)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pulse_en   (pulse_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .busy       (busy),
        .active_cfg (active_cfg),
        .sec_tick   (sec_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [7:0] c, input int idx);
        int per;
        int st;
        per = c[7] ? LONG_S : SHORT_S;
        if (idx != per - 1 || c[5:0] == 6'd0) return DIV;
        if (c[6]) begin
            st = int'((~c[5:0]) & 6'h3F) + 1;
            return DIV + 2 * st;
        end
        st = int'(c[5:0]) - 1;
        return DIV - 2 * st;
    endfunction

    // input pulse every second clock
    initial begin
        forever begin
            @(negedge clk);
            pulse_en = rst ? 1'b0 : ~pulse_en;
        end
    end

    // monitor: measures every second against the model
    initial begin
        int cnt;
        bit prev_pulse;
        bit prev_tick;
        cnt = 0;
        prev_pulse = 1'b0;
        prev_tick = 1'b0;
        wait (run_mon);
        forever begin
            @(negedge clk);
            if (pulse_en) cnt++;
            if (sec_tick) begin
                // R11: tick follows the completing pulse and is one cycle wide
                chk(prev_pulse && !prev_tick, "R11", int'(prev_pulse), 1);
                // R2 R3 R4 R5 R6: length of the finished second
                chk(cnt == exp_len(m_active, m_idx), "R5 second length (R2/R3/R4/R6)",
                    cnt, exp_len(m_active, m_idx));
                m_idx++;
                if (m_idx == (m_active[7] ? LONG_S : SHORT_S)) begin
                    m_idx = 0;
                    if (m_pvalid) begin
                        m_active = m_pend;
                        m_pvalid = 1'b0;
                    end
                end
                // R1 R8: load at boundary, busy drops with the tick
                chk(active_cfg == m_active, "R1 active word", int'(active_cfg), int'(m_active));
                chk(busy == m_pvalid, "R8 busy", int'(busy), int'(m_pvalid));
                m_ticks++;
                cnt = 0;
            end
            prev_pulse = pulse_en;
            prev_tick = sec_tick;
        end
    end

    task automatic wait_ticks(input int n);
        int start;
        start = m_ticks;
        while (m_ticks < start + n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] v);
        bit was_busy;
        logic [7:0] pend_before;
        wait_ticks(1);
        @(negedge clk);
        was_busy = busy;
        pend_before = m_pend;
        wr_en = 1'b1;
        wr_data = v;
        if (!was_busy) begin
            m_pend = v;
            m_pvalid = 1'b1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        if (!was_busy) begin
            chk(busy == 1'b1, "R7 busy after write", int'(busy), 1);
        end else begin
            chk(busy == 1'b1 && m_pend == pend_before, "R9 ignored write", int'(busy), 1);
        end
    endtask

    task automatic apply(input logic [7:0] v);
        do_write(v);
        while (m_pvalid) @(negedge clk);
        chk(active_cfg == v, "R1 loaded word", int'(active_cfg), int'(v));
        wait_ticks(v[7] ? LONG_S : SHORT_S);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        run_mon = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        chk(active_cfg == 8'h00, "R10 active after reset", int'(active_cfg), 0);
        wait_ticks(SHORT_S);

        apply(8'h02);            // R3: one step added
        apply(8'h3F);            // R3: 62 steps added
        apply(8'h01);            // R3: code 1 gives no steps
        apply(8'h7F);            // R4: one step removed
        apply(8'h41);            // R4: 63 steps removed
        apply(8'h40);            // R2: zero amount with direction set
        apply(8'h85);            // R6: long window, add 4 steps
        apply(8'hC0 | 8'h3A);    // R6/R4: long window removal

        // R9: second write while pending is dropped
        do_write(8'h0A);
        do_write(8'h4B);
        while (m_pvalid) @(negedge clk);
        chk(active_cfg == 8'h0A, "R9 first word kept", int'(active_cfg), 8'h0A);
        wait_ticks(SHORT_S);

        for (int i = 0; i < 6; i++) begin
            apply(8'($urandom));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule